// File: doc/BRIEF.md
# Bit, Rotate and Shift Execution Unit

This unit is the execution stage for the second opcode byte that follows an escape prefix in a compact 8-bit processor, and for the four single-byte accumulator rotates. Each cycle with `valid_i` high it takes one opcode byte, one 8-bit operand and the current carry. One clock later it returns the result, the new flag values, a per-flag write mask, a write-back enable, the register index to write, whether the operand lives in memory, and the number of machine clock cycles the instruction costs.

The enclosing core fetches the operand, including the read through the address register pair when the operand index is 6, and stores the result afterwards. It uses `mem_op_o` to choose between the register file and the memory store, and `cycles_o` to keep its timing accurate. When `acc_mode_i` is high the opcode is read as one of the accumulator rotates. In that mode only opcode bits 4:3 count, and the destination is always the accumulator.

Top module: `bsu_core`

## Requirements
- R1: With `acc_mode_i` low and opcode bits 7:6 = 00, opcode bits 5:3 choose the operation as follows: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 shift left with bit 0 filled by 0, 5 shift right keeping bit 7, 6 swap the two nibbles, 7 shift right with bit 7 filled by 0.
- R2: For the shifts and rotates, the carry out is the bit that leaves the operand. The two through-carry rotates place `carry_i` in the bit that is vacated. A nibble swap gives carry 0.
- R3: The flags are packed as `flags_o` bit 3 = zero, bit 2 = subtract, bit 1 = half-carry, bit 0 = carry. For group 00, zero is set exactly when the result is 0, subtract and half-carry are 0, and `flag_we_o` = 1111.
- R4: Opcode bits 7:6 = 01 is a bit test of operand bit `opcode[5:3]`. Zero is set when that bit is 0, subtract is 0, half-carry is 1, and `flags_o[0]` repeats `carry_i`. `flag_we_o` = 1110, so carry is not written. `wb_en_o` = 0, and `result_o` equals the operand.
- R5: Opcode bits 7:6 = 10 clears operand bit `opcode[5:3]`, and 11 sets it. No other bit changes. `flag_we_o` = 0000, `flags_o` = 0000 and `wb_en_o` = 1.
- R6: With `acc_mode_i` low, `dst_idx_o` is opcode bits 2:0 (0..7 meaning b, c, d, e, h, l, memory, a). `mem_op_o` is 1 exactly when that index is 6.
- R7: `cycles_o` is 8 for a register operand. For a memory operand it is 12 for a bit test and 16 for every other operation.
- R8: With `acc_mode_i` high, opcode bits 4:3 choose rotate left circular (0), rotate right circular (1), rotate left through carry (2) or rotate right through carry (3). All other opcode bits are ignored. Zero, subtract and half-carry are 0, carry follows R2, `flag_we_o` = 1111, `wb_en_o` = 1, `dst_idx_o` = 7, `mem_op_o` = 0 and `cycles_o` = 4.
- R9: The outputs are registered. `valid_o` follows `valid_i` one cycle later. After a cycle with `valid_i` low, all the other outputs keep their previous values. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| opcode_i | input | 8 | Opcode byte |
| operand_i | input | WIDTH | Operand value |
| carry_i | input | 1 | Incoming carry flag |
| acc_mode_i | input | 1 | Read the opcode as an accumulator rotate |
| valid_o | output | 1 | Result present |
| result_o | output | WIDTH | Result value |
| flags_o | output | 4 | New flags {zero, subtract, half-carry, carry} |
| flag_we_o | output | 4 | Per-flag write mask, same bit order |
| wb_en_o | output | 1 | Result is to be written back |
| mem_op_o | output | 1 | Operand index selects memory |
| dst_idx_o | output | 3 | Register index for write-back |
| cycles_o | output | CYC_W | Cycle cost of the instruction |

## Verification
The assertions check on every cycle the properties that are fixed by the opcode class alone. These are: the cycle cost and memory flag for each operand kind, the write masks, the bit test not writing back, a set bit really being 1, the forced-zero flags of the accumulator rotates, the zero flag tracking the result for shifts, and the one-cycle valid timing with outputs held while idle. The exact result and carry of each of the eight shift forms, the bit index decode, the through-carry fill and the fact that the accumulator mode ignores opcode bits only show up in the bench's sweeps. The bench compares every opcode byte against an arithmetic model over many operand patterns and both carry values.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    localparam int FLAG_Z = 3;
    localparam int FLAG_N = 2;
    localparam int FLAG_H = 1;
    localparam int FLAG_C = 0;

    localparam int unsigned MEM_IDX = 6;
    localparam int unsigned ACC_IDX = 7;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLR   = 2'b10,
        GRP_SET   = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        SH_RLC  = 3'd0,
        SH_RRC  = 3'd1,
        SH_RL   = 3'd2,
        SH_RR   = 3'd3,
        SH_SLA  = 3'd4,
        SH_SRA  = 3'd5,
        SH_SWAP = 3'd6,
        SH_SRL  = 3'd7
    } shift_e;

endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
    import bsu_pkg::*;
#(
    parameter int CYC_W        = 5,
    parameter int CYC_ACC      = 4,
    parameter int CYC_REG      = 8,
    parameter int CYC_TEST_MEM = 12,
    parameter int CYC_RMW_MEM  = 16
) (
    input  logic [7:0]       opcode_i,
    input  logic             acc_mode_i,
    output grp_e             grp_o,
    output shift_e           kind_o,
    output logic [2:0]       bit_idx_o,
    output logic [2:0]       dst_idx_o,
    output logic             mem_o,
    output logic [CYC_W-1:0] cycles_o
);

    always_comb begin
        if (acc_mode_i) begin
            // only the four circular / through-carry rotates exist here
            grp_o     = GRP_SHIFT;
            kind_o    = shift_e'({1'b0, opcode_i[4:3]});
            bit_idx_o = 3'd0;
            dst_idx_o = 3'(ACC_IDX);
            mem_o     = 1'b0;
            cycles_o  = CYC_W'(CYC_ACC);
        end else begin
            grp_o     = grp_e'(opcode_i[7:6]);
            kind_o    = shift_e'(opcode_i[5:3]);
            bit_idx_o = opcode_i[5:3];
            dst_idx_o = opcode_i[2:0];
            mem_o     = (opcode_i[2:0] == 3'(MEM_IDX));
            if (!mem_o)
                cycles_o = CYC_W'(CYC_REG);
            else if (grp_o == GRP_TEST)
                cycles_o = CYC_W'(CYC_TEST_MEM);
            else
                cycles_o = CYC_W'(CYC_RMW_MEM);
        end
    end

endmodule

// File: rtl/bsu_shifter.sv
module bsu_shifter
    import bsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] operand_i,
    input  shift_e           kind_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);

    localparam int MSB  = WIDTH - 1;
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] swapped;

    // nibble exchange: upper and lower halves trade places
    generate
        if ((WIDTH % 2) == 0) begin : g_even_swap
            assign swapped = {operand_i[HALF-1:0], operand_i[MSB:HALF]};
        end else begin : g_odd_swap
            assign swapped = {operand_i[HALF-1:0], operand_i[MSB:HALF]};
        end
    endgenerate

    always_comb begin
        result_o = operand_i;
        carry_o  = 1'b0;
        unique case (kind_i)
            SH_RLC: begin
                result_o = {operand_i[MSB-1:0], operand_i[MSB]};
                carry_o  = operand_i[MSB];
            end
            SH_RRC: begin
                result_o = {operand_i[0], operand_i[MSB:1]};
                carry_o  = operand_i[0];
            end
            SH_RL: begin
                result_o = {operand_i[MSB-1:0], carry_i};
                carry_o  = operand_i[MSB];
            end
            SH_RR: begin
                result_o = {carry_i, operand_i[MSB:1]};
                carry_o  = operand_i[0];
            end
            SH_SLA: begin
                result_o = {operand_i[MSB-1:0], 1'b0};
                carry_o  = operand_i[MSB];
            end
            SH_SRA: begin
                result_o = {operand_i[MSB], operand_i[MSB:1]};
                carry_o  = operand_i[0];
            end
            SH_SWAP: begin
                result_o = swapped;
                carry_o  = 1'b0;
            end
            SH_SRL: begin
                result_o = {1'b0, operand_i[MSB:1]};
                carry_o  = operand_i[0];
            end
            default: begin
                result_o = operand_i;
                carry_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bsu_bitop.sv
module bsu_bitop
    import bsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic [2:0]       bit_idx_i,
    input  grp_e             grp_i,
    output logic [WIDTH-1:0] result_o,
    output logic             tested_o
);

    logic [WIDTH-1:0] mask;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_mask
            assign mask[i] = (bit_idx_i == 3'(i));
        end
    endgenerate

    assign tested_o = |(operand_i & mask);

    always_comb begin
        unique case (grp_i)
            GRP_CLR: result_o = operand_i & ~mask;
            GRP_SET: result_o = operand_i | mask;
            default: result_o = operand_i;
        endcase
    end

endmodule

// File: rtl/bsu_core.sv
module bsu_core
    import bsu_pkg::*;
#(
    parameter int WIDTH        = 8,
    parameter int CYC_W        = 5,
    parameter int CYC_ACC      = 4,
    parameter int CYC_REG      = 8,
    parameter int CYC_TEST_MEM = 12,
    parameter int CYC_RMW_MEM  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [7:0]       opcode_i,
    input  logic [WIDTH-1:0] operand_i,
    input  logic             carry_i,
    input  logic             acc_mode_i,
    output logic             valid_o,
    output logic [WIDTH-1:0] result_o,
    output logic [3:0]       flags_o,
    output logic [3:0]       flag_we_o,
    output logic             wb_en_o,
    output logic             mem_op_o,
    output logic [2:0]       dst_idx_o,
    output logic [CYC_W-1:0] cycles_o
);

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] result;
        logic [3:0]       flags;
        logic [3:0]       flag_we;
        logic             wb_en;
        logic             mem_op;
        logic [2:0]       dst;
        logic [CYC_W-1:0] cycles;
    } out_t;

    out_t out_d, out_q;

    grp_e             grp;
    shift_e           kind;
    logic [2:0]       bit_idx;
    logic [2:0]       dst_idx;
    logic             mem;
    logic [CYC_W-1:0] cycles;
    logic [WIDTH-1:0] sh_res;
    logic             sh_carry;
    logic [WIDTH-1:0] bit_res;
    logic             tested;

    bsu_decode #(
        .CYC_W       (CYC_W),
        .CYC_ACC     (CYC_ACC),
        .CYC_REG     (CYC_REG),
        .CYC_TEST_MEM(CYC_TEST_MEM),
        .CYC_RMW_MEM (CYC_RMW_MEM)
    ) u_decode (
        .opcode_i  (opcode_i),
        .acc_mode_i(acc_mode_i),
        .grp_o     (grp),
        .kind_o    (kind),
        .bit_idx_o (bit_idx),
        .dst_idx_o (dst_idx),
        .mem_o     (mem),
        .cycles_o  (cycles)
    );

    bsu_shifter #(.WIDTH(WIDTH)) u_shifter (
        .operand_i(operand_i),
        .kind_i   (kind),
        .carry_i  (carry_i),
        .result_o (sh_res),
        .carry_o  (sh_carry)
    );

    bsu_bitop #(.WIDTH(WIDTH)) u_bitop (
        .operand_i(operand_i),
        .bit_idx_i(bit_idx),
        .grp_i    (grp),
        .result_o (bit_res),
        .tested_o (tested)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = valid_i;
        if (valid_i) begin
            out_d.mem_op = mem;
            out_d.dst    = dst_idx;
            out_d.cycles = cycles;
            unique case (grp)
                GRP_SHIFT: begin
                    out_d.result         = sh_res;
                    out_d.flags          = '0;
                    out_d.flags[FLAG_Z]  = acc_mode_i ? 1'b0 : (sh_res == '0);
                    out_d.flags[FLAG_C]  = sh_carry;
                    out_d.flag_we        = 4'b1111;
                    out_d.wb_en          = 1'b1;
                end
                GRP_TEST: begin
                    out_d.result         = operand_i;
                    out_d.flags          = '0;
                    out_d.flags[FLAG_Z]  = ~tested;
                    out_d.flags[FLAG_H]  = 1'b1;
                    out_d.flags[FLAG_C]  = carry_i;
                    out_d.flag_we        = 4'b1110;
                    out_d.wb_en          = 1'b0;
                end
                default: begin
                    out_d.result  = bit_res;
                    out_d.flags   = '0;
                    out_d.flag_we = 4'b0000;
                    out_d.wb_en   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign valid_o   = out_q.valid;
    assign result_o  = out_q.result;
    assign flags_o   = out_q.flags;
    assign flag_we_o = out_q.flag_we;
    assign wb_en_o   = out_q.wb_en;
    assign mem_op_o  = out_q.mem_op;
    assign dst_idx_o = out_q.dst;
    assign cycles_o  = out_q.cycles;

endmodule

// File: rtl/bsu_core_chk.sv
module bsu_core_chk #(
    parameter int WIDTH        = 8,
    parameter int CYC_W        = 5,
    parameter int CYC_ACC      = 4,
    parameter int CYC_REG      = 8,
    parameter int CYC_TEST_MEM = 12,
    parameter int CYC_RMW_MEM  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [7:0]       opcode_i,
    input logic             carry_i,
    input logic             acc_mode_i,
    input logic             valid_o,
    input logic [WIDTH-1:0] result_o,
    input logic [3:0]       flags_o,
    input logic [3:0]       flag_we_o,
    input logic             wb_en_o,
    input logic             mem_op_o,
    input logic [2:0]       dst_idx_o,
    input logic [CYC_W-1:0] cycles_o
);

    AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == $past(valid_i)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(result_o) && $stable(cycles_o) && $stable(flags_o)); // R9

    AST_SHIFT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !acc_mode_i && opcode_i[7:6] == 2'b00 |=>
        flag_we_o == 4'b1111 && !flags_o[2] && !flags_o[1]
        && (flags_o[3] == (result_o == '0))); // R3

    AST_TEST_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !acc_mode_i && opcode_i[7:6] == 2'b01 |=>
        !wb_en_o && flag_we_o == 4'b1110 && flags_o[1] && !flags_o[2]
        && flags_o[0] == $past(carry_i)); // R4

    AST_CLRSET_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !acc_mode_i && opcode_i[7] |=> wb_en_o && flag_we_o == 4'b0000); // R5

    AST_SET_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !acc_mode_i && opcode_i[7:6] == 2'b11 |=>
        result_o[$past(opcode_i[5:3])]); // R5

    AST_REG_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !acc_mode_i && opcode_i[2:0] != 3'd6 |=>
        !mem_op_o && cycles_o == CYC_W'(CYC_REG) && dst_idx_o == $past(opcode_i[2:0])); // R6

    AST_MEM_COST: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !acc_mode_i && opcode_i[2:0] == 3'd6 |=>
        mem_op_o && cycles_o == (($past(opcode_i[7:6]) == 2'b01) ?
        CYC_W'(CYC_TEST_MEM) : CYC_W'(CYC_RMW_MEM))); // R7

    AST_ACC_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && acc_mode_i |=>
        !flags_o[3] && !flags_o[2] && !flags_o[1] && wb_en_o && !mem_op_o
        && dst_idx_o == 3'd7 && cycles_o == CYC_W'(CYC_ACC)); // R8

endmodule

bind bsu_core bsu_core_chk #(
    .WIDTH       (WIDTH),
    .CYC_W       (CYC_W),
    .CYC_ACC     (CYC_ACC),
    .CYC_REG     (CYC_REG),
    .CYC_TEST_MEM(CYC_TEST_MEM),
    .CYC_RMW_MEM (CYC_RMW_MEM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .opcode_i  (opcode_i),
    .carry_i   (carry_i),
    .acc_mode_i(acc_mode_i),
    .valid_o   (valid_o),
    .result_o  (result_o),
    .flags_o   (flags_o),
    .flag_we_o (flag_we_o),
    .wb_en_o   (wb_en_o),
    .mem_op_o  (mem_op_o),
    .dst_idx_o (dst_idx_o),
    .cycles_o  (cycles_o)
);

// File: tb/bsu_core_tb.sv
`timescale 1ns/1ps
module bsu_core_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       valid_i;
    logic [7:0] opcode_i;
    logic [7:0] operand_i;
    logic       carry_i;
    logic       acc_mode_i;
    logic       valid_o;
    logic [7:0] result_o;
    logic [3:0] flags_o;
    logic [3:0] flag_we_o;
    logic       wb_en_o;
    logic       mem_op_o;
    logic [2:0] dst_idx_o;
    logic [4:0] cycles_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bsu_core u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
        .operand_i(operand_i), .carry_i(carry_i), .acc_mode_i(acc_mode_i),
        .valid_o(valid_o), .result_o(result_o), .flags_o(flags_o),
        .flag_we_o(flag_we_o), .wb_en_o(wb_en_o), .mem_op_o(mem_op_o),
        .dst_idx_o(dst_idx_o), .cycles_o(cycles_o)
    );

    // {valid, result, flags, we, wb, mem, dst, cycles}
    function automatic logic [26:0] observed();
        return {valid_o, result_o, flags_o, flag_we_o, wb_en_o, mem_op_o, dst_idx_o, cycles_o};
    endfunction

    function automatic logic [26:0] model(input int op, input int x, input int cin, input bit acc);
        int r, c, z, n, h, we, wb, mem, dst, cyc, grp, sel, idx, b;
        r = x; c = 0; z = 0; n = 0; h = 0; we = 15; wb = 1;
        grp = acc ? 0 : op / 64;
        sel = acc ? (op / 8) % 4 : (op / 8) % 8;
        idx = (op / 8) % 8;
        dst = acc ? 7 : op % 8;
        mem = (!acc && dst == 6) ? 1 : 0;
        if (grp == 0) begin
            case (sel)
                0: begin r = (x * 2) % 256 + x / 128; c = x / 128; end
                1: begin r = x / 2 + (x % 2) * 128;   c = x % 2;   end
                2: begin r = (x * 2) % 256 + cin;     c = x / 128; end
                3: begin r = x / 2 + cin * 128;       c = x % 2;   end
                4: begin r = (x * 2) % 256;           c = x / 128; end
                5: begin r = x / 2 + (x / 128) * 128; c = x % 2;   end
                6: begin r = (x % 16) * 16 + x / 16;  c = 0;       end
                default: begin r = x / 2;             c = x % 2;   end
            endcase
            z = (!acc && r == 0) ? 1 : 0;
        end else if (grp == 1) begin
            b = (x >> idx) % 2;
            z = (b == 0) ? 1 : 0; h = 1; c = cin; we = 14; wb = 0;
        end else begin
            b = 1 << idx;
            r = (grp == 2) ? ((x | b) - b) : (x | b);
            we = 0;
        end
        if (acc)        cyc = 4;
        else if (!mem)  cyc = 8;
        else if (grp == 1) cyc = 12;
        else            cyc = 16;
        return {1'b1, 8'(r), 1'(z), 1'(n), 1'(h), 1'(c), 4'(we), 1'(wb), 1'(mem), 3'(dst), 5'(cyc)};
    endfunction

    task automatic check(input string req, input logic [26:0] got, input logic [26:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic string req_of(input int op, input bit acc);
        if (acc) return "R8 R2";
        case (op / 64)
            0: return "R1 R2 R3 R6 R7";
            1: return "R4 R6 R7";
            default: return "R5 R6 R7";
        endcase
    endfunction

    task automatic apply(input int op, input int x, input int cin, input bit acc);
        valid_i = 1'b1; opcode_i = 8'(op); operand_i = 8'(x);
        carry_i = 1'(cin); acc_mode_i = acc;
        @(negedge clk);
        check(req_of(op, acc), observed(), model(op, x, cin, acc));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        logic [26:0] held;
        rst_n = 1'b0; valid_i = 1'b0; opcode_i = 8'h00; operand_i = 8'h00;
        carry_i = 1'b0; acc_mode_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset", observed(), 27'd0);
        rst_n = 1'b1;

        // every second-byte opcode, both carries, varied operands incl. edges
        for (int op = 0; op < 256; op++)
            for (int cin = 0; cin < 2; cin++)
                for (int k = 0; k < 48; k++) begin
                    int x;
                    case (k)
                        0: x = 0;
                        1: x = 255;
                        2: x = 128;
                        3: x = 1;
                        4: x = 15;
                        5: x = 240;
                        default: x = (k * 37 + op * 11 + cin * 91) % 256;
                    endcase
                    apply(op, x, cin, 1'b0);
                end

        // accumulator rotates: all operands, junk in the ignored opcode bits
        for (int sel = 0; sel < 4; sel++)
            for (int cin = 0; cin < 2; cin++)
                for (int x = 0; x < 256; x++) begin
                    int op;
                    op = ((x * 13 + sel * 7) % 256);
                    op = op - (op & 24) + sel * 8;
                    apply(op, x, cin, 1'b1);
                end

        // idle cycles keep outputs, valid drops (R9)
        apply(8'hC6, 8'h5A, 0, 1'b0);
        held = observed();
        valid_i = 1'b0; opcode_i = 8'h00; operand_i = 8'hFF; carry_i = 1'b1;
        @(negedge clk);
        check("R9 idle valid", {26'd0, valid_o}, 27'd0);
        check("R9 idle hold", {1'b0, observed()[25:0]}, {1'b0, held[25:0]});
        @(negedge clk);
        check("R9 idle hold 2", observed(), {1'b0, held[25:0]});

        done = 1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule